// File: doc/BRIEF.md
# Window/Timeout Software Watchdog with Safe Mode

This block supervises a microcontroller that must prove it is alive by writing a service strobe at the right moment. A periodic millisecond tick advances a period counter. The period is one of four lengths, chosen by a 2-bit code. In timeout mode, any service before the period runs out is accepted. In window mode, the first half of the period is closed and only the second half accepts service. A service that comes too early, or no service at all, is a watchdog failure.

A failure always pulls the active-low watchdog-status output low. That output stays low until a later valid service. In the normal supervision mode, a failure also pulls the reset output low for a short pulse. In safe mode, reset is left alone and only the status output reports the failure. A sticky flag records that a failure happened and clears only when it is read.

A supply-undervoltage input pulls reset low on its own for as long as the input stays asserted. It freezes the watchdog but does not touch the status output. The tick source and the serial register decode sit outside this block.

Top module: `wdog_supervisor`

## Requirements
- R1: `per_sel` selects the period in ticks: code 0 = 10, 1 = 50, 2 = 100, 3 = 400. If no valid service arrives, the failure takes effect at the clock edge that carries the period-th tick after the counter restarted.
- R2: With `win_mode` = 1, a service taken while fewer than half the period's ticks have elapsed since restart is a failure.
- R3: With `win_mode` = 1, a service taken at or after half the period is valid. With `win_mode` = 0, any service before expiry is valid. A valid service restarts the period count from zero.
- R4: With `safe_mode` = 0, a failure drives `rst_out_n` low from the next clock edge for `RST_TICKS` ticks (default 1). The period count restarts from zero once the pulse ends.
- R5: With `safe_mode` = 1, a failure leaves `rst_out_n` high.
- R6: `wd_status_n` goes low on every failure and stays low until the next valid service sets it high again.
- R7: `wd_fail_flag` is set on every failure. It is cleared by `flag_rd` and not by a valid service. If a failure and a read fall in the same cycle, the failure wins.
- R8: While `supply_low` is 1, `rst_out_n` is low from the following edge. During that time the watchdog neither counts nor fails, and `wd_status_n` is unchanged. `rst_out_n` returns high one edge after `supply_low` falls.
- R9: While `wd_en` is 0, the period count is held at zero, services are ignored and no failure occurs.
- R10: After reset, `rst_out_n` = 1, `wd_status_n` = 1 and `wd_fail_flag` = 0.
- R11: A valid service that lands in the same cycle as the period's final tick wins over expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle time-base tick |
| svc_strobe | input | 1 | Watchdog service write |
| per_sel | input | 2 | Period select code |
| win_mode | input | 1 | 1 = window, 0 = timeout |
| safe_mode | input | 1 | 1 = failures do not reset |
| wd_en | input | 1 | Watchdog run enable |
| supply_low | input | 1 | Supply undervoltage indication |
| flag_rd | input | 1 | Read strobe that clears the sticky flag |
| rst_out_n | output | 1 | Active-low reset to the MCU |
| wd_status_n | output | 1 | Active-low watchdog-failure status |
| wd_fail_flag | output | 1 | Sticky failure-occurred flag |

## Verification
A period counter that is off by one moves the boundary between the closed and open halves. That error shows up at once as a changed status level one edge after a service placed exactly at the half-period or final-tick position. A counter that fails to restart after a reset pulse or a valid service shows up later, as a spurious status drop within one period of a service that should have been accepted. A reset-pulse timer that stalls keeps `rst_out_n` low past the single expected cycle. Mishandled safe mode or undervoltage is visible on `rst_out_n` and `wd_status_n` on the very next edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    PSEL_SHORT  = 2'd0,
    PSEL_MID    = 2'd1,
    PSEL_LONG   = 2'd2,
    PSEL_XLONG  = 2'd3
  } per_sel_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/wdog_period_ctr.sv
module wdog_period_ctr #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic             window,
  input  logic [CNT_W-1:0] period,
  output logic             expire,
  output logic             closed
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] half_idx;

  assign last_idx = period - CNT_W'(1);
  assign half_idx = period >> 1;

  // expiry uses >= so a period shortened mid-run still ends
  assign expire = run & tick & (cnt_q >= last_idx);
  assign closed = window & (cnt_q < half_idx);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned RST_TICKS = 1,
  parameter int unsigned PW        = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic supply_low,
  output logic active
);

  logic          act_q, act_d;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    act_d = act_q;
    pc_d  = pc_q;
    if (supply_low) begin
      act_d = 1'b0;
      pc_d  = '0;
    end else if (start) begin
      act_d = 1'b1;
      pc_d  = '0;
    end else if (act_q && tick) begin
      if (pc_q == PW'(RST_TICKS - 1)) begin
        act_d = 1'b0;
        pc_d  = '0;
      end else begin
        pc_d = pc_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      act_q <= act_d;
      pc_q  <= pc_d;
    end
  end

  assign active = act_q;

  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (pc_q < PW'(RST_TICKS)));

  a_r8_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !act_q);

endmodule

// File: rtl/wdog_status_track.sv
module wdog_status_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic svc_ok,
  input  logic flag_rd,
  output logic status_n,
  output logic flag
);

  logic st_q, st_d;
  logic fl_q, fl_d;

  always_comb begin
    st_d = st_q;
    if (fail)        st_d = 1'b0;
    else if (svc_ok) st_d = 1'b1;
    fl_d = fl_q;
    if (fail)         fl_d = 1'b1;
    else if (flag_rd) fl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b1;
      fl_q <= 1'b0;
    end else begin
      st_q <= st_d;
      fl_q <= fl_d;
    end
  end

  assign status_n = st_q;
  assign flag     = fl_q;

  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q && !svc_ok) |=> !st_q);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q && !flag_rd) |=> fl_q);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int unsigned PER0_TICKS = 10,
  parameter int unsigned PER1_TICKS = 50,
  parameter int unsigned PER2_TICKS = 100,
  parameter int unsigned PER3_TICKS = 400,
  parameter int unsigned RST_TICKS  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       svc_strobe,
  input  logic [1:0] per_sel,
  input  logic       win_mode,
  input  logic       safe_mode,
  input  logic       wd_en,
  input  logic       supply_low,
  input  logic       flag_rd,
  output logic       rst_out_n,
  output logic       wd_status_n,
  output logic       wd_fail_flag
);

  localparam int unsigned PER_MAX = max4(PER0_TICKS, PER1_TICKS, PER2_TICKS, PER3_TICKS);
  localparam int unsigned CNT_W   = bits_for(PER_MAX);
  localparam int unsigned PW      = bits_for(RST_TICKS);
  localparam int unsigned NPER    = 4;
  localparam int unsigned PER_TAB [NPER] = '{PER0_TICKS, PER1_TICKS, PER2_TICKS, PER3_TICKS};

  logic [CNT_W-1:0] per_opt [NPER];
  logic [CNT_W-1:0] period;
  logic             run, restart, expire, closed;
  logic             svc_ok, svc_bad, fail;
  logic             pulse_act;
  logic             sup_q;

  for (genvar g = 0; g < NPER; g++) begin : g_per
    assign per_opt[g] = CNT_W'(PER_TAB[g]);
  end

  assign period = per_opt[per_sel];

  assign run     = wd_en & ~pulse_act & ~supply_low;
  assign svc_ok  = run & svc_strobe & ~closed;
  assign svc_bad = run & svc_strobe & closed;
  assign fail    = svc_bad | (expire & ~svc_ok);
  assign restart = svc_ok | fail;

  wdog_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick),
    .run     (run),
    .restart (restart),
    .window  (win_mode),
    .period  (period),
    .expire  (expire),
    .closed  (closed)
  );

  wdog_rst_pulse #(.RST_TICKS(RST_TICKS), .PW(PW)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (ms_tick),
    .start      (fail & ~safe_mode),
    .supply_low (supply_low),
    .active     (pulse_act)
  );

  wdog_status_track u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail     (fail),
    .svc_ok   (svc_ok),
    .flag_rd  (flag_rd),
    .status_n (wd_status_n),
    .flag     (wd_fail_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q <= 1'b0;
    end else begin
      sup_q <= supply_low;
    end
  end

  assign rst_out_n = ~(pulse_act | sup_q);

  a_r5_safe_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && safe_mode && !supply_low && !pulse_act) |=> rst_out_n);

  a_r6_fail_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !wd_status_n);

  a_r7_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> wd_fail_flag);

  a_r8_supply_reset: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !rst_out_n);

  a_r9_no_fail_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && wd_status_n) |=> wd_status_n);

endmodule

// File: tb/tb_wdog_supervisor.sv
`timescale 1ns/1ps
module tb_wdog_supervisor;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick, svc_strobe, win_mode, safe_mode, wd_en, supply_low, flag_rd;
  logic [1:0] per_sel;
  logic rst_out_n, wd_status_n, wd_fail_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wdog_supervisor dut (
    .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .svc_strobe (svc_strobe),
    .per_sel (per_sel), .win_mode (win_mode), .safe_mode (safe_mode),
    .wd_en (wd_en), .supply_low (supply_low), .flag_rd (flag_rd),
    .rst_out_n (rst_out_n), .wd_status_n (wd_status_n), .wd_fail_flag (wd_fail_flag)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        win;
    logic        safe;
    logic [9:0]  wait_n;
    logic        noclr;
    logic        efail;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b0, 10'd2,   1'b0, 1'b1},  // R2 closed half
    '{2'd0, 1'b1, 1'b0, 10'd5,   1'b0, 1'b0},  // R3 first open tick
    '{2'd0, 1'b1, 1'b0, 10'd4,   1'b0, 1'b1},  // R2 last closed tick
    '{2'd1, 1'b1, 1'b1, 10'd24,  1'b0, 1'b1},  // R5 safe closed
    '{2'd1, 1'b1, 1'b0, 10'd30,  1'b0, 1'b0},  // R3 open
    '{2'd1, 1'b0, 1'b0, 10'd3,   1'b0, 1'b0},  // R3 timeout mode early
    '{2'd2, 1'b0, 1'b0, 10'd0,   1'b1, 1'b1},  // R1 expiry
    '{2'd2, 1'b1, 1'b1, 10'd99,  1'b0, 1'b0},  // R11 final tick
    '{2'd3, 1'b1, 1'b0, 10'd199, 1'b0, 1'b1},  // R2 long period
    '{2'd3, 1'b1, 1'b0, 10'd200, 1'b0, 1'b0},  // R3 long period
    '{2'd3, 1'b0, 1'b1, 10'd0,   1'b1, 1'b1},  // R1 R5 expiry safe
    '{2'd0, 1'b0, 1'b0, 10'd9,   1'b0, 1'b0}   // R11 timeout final
  };

  function automatic int per_of(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 50;
      2'd2: return 100;
      default: return 400;
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic arm(input logic [1:0] s, input logic w, input logic sf);
    while (rst_out_n !== 1'b1) @(negedge clk);
    wd_en = 1'b0; per_sel = s; win_mode = w; safe_mode = sf;
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    @(negedge clk);
    wd_en = 1'b1;
  endtask

  task automatic service_after(input int w);
    repeat (w) @(posedge clk);
    @(negedge clk);
    svc_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    svc_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; ms_tick = 1'b1; svc_strobe = 1'b0; per_sel = 2'd0;
    win_mode = 1'b1; safe_mode = 1'b0; wd_en = 1'b0; supply_low = 1'b0; flag_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rst_out_n", rst_out_n, 1'b1);
    check("R10 wd_status_n", wd_status_n, 1'b1);
    check("R10 wd_fail_flag", wd_fail_flag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      arm(VECS[i].sel, VECS[i].win, VECS[i].safe);
      if (VECS[i].noclr) begin
        repeat (per_of(VECS[i].sel)) @(posedge clk);
        @(negedge clk);
      end else begin
        service_after(int'(VECS[i].wait_n));
      end
      check("R6 status vec", wd_status_n, ~VECS[i].efail);
      check("R7 flag vec", wd_fail_flag, VECS[i].efail);
      check("R4/R5 rst vec", rst_out_n, ~(VECS[i].efail & ~VECS[i].safe));
    end

    // R4: pulse length and counter restart after the pulse
    arm(2'd0, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R4 pulse low", rst_out_n, 1'b0);
    @(negedge clk);
    check("R4 pulse ended", rst_out_n, 1'b1);
    service_after(8);
    check("R4 restart valid service", wd_status_n, 1'b1);
    check("R7 flag kept over service", wd_fail_flag, 1'b1);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    check("R7 flag cleared by read", wd_fail_flag, 1'b0);

    // R8: undervoltage
    arm(2'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    check("R8 rst low", rst_out_n, 1'b0);
    repeat (30) @(negedge clk);
    check("R8 rst held", rst_out_n, 1'b0);
    check("R8 status unchanged", wd_status_n, 1'b1);
    check("R8 no failure", wd_fail_flag, 1'b0);
    supply_low = 1'b0;
    @(negedge clk);
    check("R8 rst released", rst_out_n, 1'b1);
    service_after(4);
    check("R8 counter restarted", wd_status_n, 1'b1);

    // R9: disabled watchdog ignores time and services
    wd_en = 1'b0; win_mode = 1'b1;
    repeat (30) @(negedge clk);
    svc_strobe = 1'b1;
    @(negedge clk);
    svc_strobe = 1'b0;
    @(negedge clk);
    check("R9 status high", wd_status_n, 1'b1);
    check("R9 flag clear", wd_fail_flag, 1'b0);
    check("R9 rst high", rst_out_n, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule